// File: doc/BRIEF.md
# Received Character Flow-Control and Special-Character Filter

This block sits between a serial receiver and its receive FIFO. Every time the receiver completes a character, the block compares that character with four programmable software flow-control characters: two "stop" characters and two "resume" characters. The comparison decides three things: whether the character goes into the FIFO, whether the transmitter is asked to pause or continue, and whether a special-character event is flagged.

A 2-bit compare mode selects which stop/resume pair is active. The special-character detector always compares against the second stop character. In the mode that uses the first pair, the detector runs independently of flow control. In the mode that uses the second pair, one match on the second stop character acts as both a stop request and a special-character detection, and the character is dropped.

All results are registered. They appear one clock after the receive strobe.

Top module: `sfc_char_filter`

## Requirements
- R1: While reset is held, and in the first cycle after release, the outputs `fifo_wr`, `tx_stop`, `tx_resume`, `xoff_irq`, `spec_irq` and `spec_flag` are all 0.
- R2: When a character matches nothing active, `fifo_wr` pulses for exactly one cycle, one clock after `rx_valid`, and `fifo_data` carries the character. In that cycle the stop and resume outputs stay 0.
- R3: With `spec_en` = 0, a character equal to `xoff2_chr` does not set `spec_flag`. Outside mode 2'b01 it is also written to the FIFO.
- R4: With `spec_en` = 1 and `fc_mode` 2'b00, 2'b10 or 2'b11, a character equal to `xoff2_chr` is still written to the FIFO, and `spec_flag` becomes 1 one clock after `rx_valid`.
- R5: `spec_irq` pulses one clock after a special-character match only when `spec_irq_en` = 1. With `spec_irq_en` = 0 it stays 0.
- R6: With `fc_mode` = 2'b10, a character equal to `xoff1_chr` pulses `tx_stop` and `xoff_irq` and is not written. A character equal to `xon1_chr` pulses `tx_resume` and is not written.
- R7: With `fc_mode` = 2'b01, a character equal to `xoff2_chr` is not written and pulses `tx_stop` and `xoff_irq`. If `spec_en` = 1, it also sets `spec_flag`, and it pulses `spec_irq` when `spec_irq_en` = 1.
- R8: With `fc_mode` = 2'b01, a character equal to `xon2_chr` pulses `tx_resume` and is not written. A character equal to `xon1_chr` is written normally.
- R9: With `fc_mode` 2'b00 or 2'b11, no flow-control matching takes place, so a character equal to `xoff1_chr` or `xon1_chr` is written.
- R10: `spec_flag` stays 1 until a cycle with `stat_clr` = 1 and no new match. If a match and `stat_clr` arrive together, the flag stays 1.
- R11: When the selected resume and stop characters are equal, a matching character counts as a stop: only `tx_stop` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received character, bit 0 = first/LSB bit |
| xon1_chr | input | 8 | Resume character of pair 1 |
| xon2_chr | input | 8 | Resume character of pair 2 |
| xoff1_chr | input | 8 | Stop character of pair 1 |
| xoff2_chr | input | 8 | Stop character of pair 2, also the special character |
| fc_mode | input | 2 | 2'b10 pair 1, 2'b01 pair 2, 2'b00/2'b11 no flow matching |
| spec_en | input | 1 | Special-character detection enable |
| spec_irq_en | input | 1 | Special-character interrupt enable |
| stat_clr | input | 1 | Status-read clear pulse for the special flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Character to write |
| spec_flag | output | 1 | Sticky special-character status |
| spec_irq | output | 1 | Special-character interrupt pulse |
| xoff_irq | output | 1 | Stop-character interrupt pulse |
| tx_stop | output | 1 | Pause-transmit request pulse |
| tx_resume | output | 1 | Resume-transmit request pulse |

## Verification
The bench targets the second stop character in each mode.
- In mode 2'b10, it must be written and flagged. A design that mixes up the two pairs would drop it or pause the transmitter.
- In mode 2'b01, it must be dropped while still setting the flag. A design that treats the two detectors as exclusive would lose one of those effects.
- Setting the flag in the same cycle as a clear must leave it set. A design that lets the clear win loses a detection.
- Equal resume and stop characters must produce only a stop. A design without a priority would emit both requests.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    FC_OFF   = 2'b00,
    FC_PAIR2 = 2'b01,
    FC_PAIR1 = 2'b10,
    FC_OFF_B = 2'b11
  } fc_mode_e;

  typedef struct packed {
    logic stop;
    logic resume;
    logic special;
    logic keep;
  } hit_t;
endpackage

// File: rtl/sfc_match.sv
module sfc_match
  import sfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] data,
  input  logic [W-1:0] xon1,
  input  logic [W-1:0] xon2,
  input  logic [W-1:0] xoff1,
  input  logic [W-1:0] xoff2,
  input  logic [1:0]   mode,
  input  logic         spec_en,
  output hit_t         hit
);
  fc_mode_e    mode_e;
  logic        fc_on;
  logic [W-1:0] sel_on;
  logic [W-1:0] sel_off;
  logic        off_eq;
  logic        on_eq;

  always_comb begin
    mode_e  = fc_mode_e'(mode);
    fc_on   = (mode_e == FC_PAIR1) || (mode_e == FC_PAIR2);
    sel_on  = (mode_e == FC_PAIR1) ? xon1 : xon2;
    sel_off = (mode_e == FC_PAIR1) ? xoff1 : xoff2;
    off_eq  = fc_on && (data == sel_off);
    on_eq   = fc_on && (data == sel_on);
    // stop wins when both selected characters are equal
    hit.stop    = off_eq;
    hit.resume  = on_eq && !off_eq;
    hit.special = spec_en && (data == xoff2);
    hit.keep    = !(off_eq || on_eq);
  end
endmodule

// File: rtl/sfc_status.sv
module sfc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;
  logic flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q); // R10
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> flag_q); // R10
endmodule

// File: rtl/sfc_char_filter.sv
module sfc_char_filter
  import sfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic [W-1:0] xon1_chr,
  input  logic [W-1:0] xon2_chr,
  input  logic [W-1:0] xoff1_chr,
  input  logic [W-1:0] xoff2_chr,
  input  logic [1:0]   fc_mode,
  input  logic         spec_en,
  input  logic         spec_irq_en,
  input  logic         stat_clr,
  output logic         fifo_wr,
  output logic [W-1:0] fifo_data,
  output logic         spec_flag,
  output logic         spec_irq,
  output logic         xoff_irq,
  output logic         tx_stop,
  output logic         tx_resume
);
  hit_t         hit;
  logic         wr_d, stop_d, res_d, sirq_d;
  logic         wr_q, stop_q, res_q, sirq_q;
  logic [W-1:0] data_q;
  logic         spec_set;

  sfc_match #(.W(W)) match_i (
    .data(rx_data), .xon1(xon1_chr), .xon2(xon2_chr),
    .xoff1(xoff1_chr), .xoff2(xoff2_chr), .mode(fc_mode),
    .spec_en(spec_en), .hit(hit)
  );

  always_comb begin
    spec_set = rx_valid && hit.special;
    wr_d     = rx_valid && hit.keep;
    stop_d   = rx_valid && hit.stop;
    res_d    = rx_valid && hit.resume;
    sirq_d   = spec_set && spec_irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      stop_q <= 1'b0;
      res_q  <= 1'b0;
      sirq_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      stop_q <= stop_d;
      res_q  <= res_d;
      sirq_q <= sirq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (rx_valid) data_q <= rx_data;
  end

  sfc_status status_i (
    .clk(clk), .rst_n(rst_n), .set_i(spec_set), .clr_i(stat_clr), .flag_o(spec_flag)
  );

  assign fifo_wr   = wr_q;
  assign fifo_data = data_q;
  assign tx_stop   = stop_q;
  assign xoff_irq  = stop_q;
  assign tx_resume = res_q;
  assign spec_irq  = sirq_q;

  AST_WR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid)); // R2
  AST_WR_NOT_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (!tx_stop && !tx_resume)); // R2
  AST_STOP_OVER_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_stop && tx_resume)); // R11
  AST_SIRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    spec_irq |-> $past(spec_irq_en)); // R5
  AST_SIRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    spec_irq |-> spec_flag); // R5
  AST_NO_FLOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fc_mode[0] == fc_mode[1]) |=> (!tx_stop && !tx_resume)); // R9
endmodule

// File: tb/sfc_char_filter_tb_top.sv
module sfc_char_filter_tb_top;
  typedef struct packed {
    logic       wr;
    logic [7:0] data;
    logic       stop;
    logic       res;
    logic       sirq;
    logic       flag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [7:0] xon1_chr = 8'h11, xon2_chr = 8'h21, xoff1_chr = 8'h13, xoff2_chr = 8'h23;
  logic [1:0] fc_mode = 2'b00;
  logic spec_en = 1'b0, spec_irq_en = 1'b0, stat_clr = 1'b0;
  logic fifo_wr, spec_flag, spec_irq, xoff_irq, tx_stop, tx_resume;
  logic [7:0] fifo_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit flag_m = 1'b0;
  bit mon_on = 1'b0;
  exp_t q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sfc_char_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .xon1_chr(xon1_chr), .xon2_chr(xon2_chr), .xoff1_chr(xoff1_chr), .xoff2_chr(xoff2_chr),
    .fc_mode(fc_mode), .spec_en(spec_en), .spec_irq_en(spec_irq_en), .stat_clr(stat_clr),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .spec_flag(spec_flag), .spec_irq(spec_irq),
    .xoff_irq(xoff_irq), .tx_stop(tx_stop), .tx_resume(tx_resume)
  );

  function automatic exp_t model(input logic [7:0] d, input logic clr);
    exp_t e;
    logic fc, off, on, sp;
    fc  = (fc_mode == 2'b10) || (fc_mode == 2'b01);
    off = fc && (d == ((fc_mode == 2'b10) ? xoff1_chr : xoff2_chr));
    on  = fc && (d == ((fc_mode == 2'b10) ? xon1_chr : xon2_chr)) && !off;
    sp  = spec_en && (d == xoff2_chr);
    e.wr   = !(off || on);
    e.data = d;
    e.stop = off;
    e.res  = on;
    e.sirq = sp && spec_irq_en;
    if (clr) flag_m = 1'b0;
    if (sp)  flag_m = 1'b1;
    e.flag = flag_m;
    return e;
  endfunction

  task automatic send(input logic [7:0] d, input string tag, input logic clr = 1'b0);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    stat_clr = clr;
    q.push_back(model(d, clr));
    tag_q.push_back(tag);
    @(negedge clk);
    rx_valid = 1'b0;
    stat_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    stat_clr = 1'b1;
    flag_m = 1'b0;
    @(negedge clk);
    stat_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    automatic logic was = rx_valid;
    #5;
    if (mon_on) begin
      if (was && q.size() > 0) begin
        automatic exp_t e = q.pop_front();
        automatic string t = tag_q.pop_front();
        checks++;
        if (fifo_wr !== e.wr || (e.wr && fifo_data !== e.data) || tx_stop !== e.stop ||
            xoff_irq !== e.stop || tx_resume !== e.res || spec_irq !== e.sirq ||
            spec_flag !== e.flag) begin
          errors++;
          $display("FAIL %s: got wr=%b d=%h stop=%b xirq=%b res=%b sirq=%b flag=%b exp wr=%b d=%h stop=%b res=%b sirq=%b flag=%b",
                   t, fifo_wr, fifo_data, tx_stop, xoff_irq, tx_resume, spec_irq, spec_flag,
                   e.wr, e.data, e.stop, e.res, e.sirq, e.flag);
        end
      end else begin
        checks++;
        if (fifo_wr || tx_stop || tx_resume || xoff_irq || spec_irq || spec_flag !== flag_m) begin
          errors++;
          $display("FAIL R2/R10 idle: got wr=%b stop=%b res=%b xirq=%b sirq=%b flag=%b exp pulses 0 flag=%b",
                   fifo_wr, tx_stop, tx_resume, xoff_irq, spec_irq, spec_flag, flag_m);
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (fifo_wr || tx_stop || tx_resume || xoff_irq || spec_irq || spec_flag) begin
      errors++;
      $display("FAIL R1 in reset: got nonzero outputs exp all 0");
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (fifo_wr || tx_stop || tx_resume || xoff_irq || spec_irq || spec_flag) begin
      errors++;
      $display("FAIL R1 after release: got nonzero outputs exp all 0");
    end
    mon_on = 1'b1;

    // mode 00: no flow matching
    send(8'h41, "R2 plain char mode00");
    send(8'h13, "R9 xoff1 in mode00 written");
    send(8'h11, "R9 xon1 in mode00 written");
    send(8'h23, "R3 xoff2 with detect off");
    send(8'h00, "R2 zero char");
    send(8'hFF, "R2 all-ones char");
    fc_mode = 2'b11;
    send(8'h13, "R9 xoff1 in mode11 written");

    // mode 10: pair 1 plus independent special detect
    fc_mode = 2'b10;
    send(8'h13, "R6 xoff1 stops");
    send(8'h11, "R6 xon1 resumes");
    send(8'h21, "R6 xon2 not active in mode10");
    spec_en = 1'b1;
    send(8'h23, "R4 special in mode10 written, flag set");
    send(8'h55, "R10 flag held across chars");
    clear_flag();
    send(8'h56, "R10 flag cleared");
    spec_irq_en = 1'b1;
    send(8'h23, "R5 special irq enabled");
    send(8'h23, "R10 match with clear keeps flag", 1'b1);
    clear_flag();

    // mode 01: second pair, xoff2 is stop and special
    fc_mode = 2'b01;
    send(8'h23, "R7 xoff2 dropped, stop, special irq");
    clear_flag();
    spec_irq_en = 1'b0;
    send(8'h23, "R5 special no irq when disabled");
    clear_flag();
    spec_en = 1'b0;
    send(8'h23, "R7 xoff2 stop without detect");
    send(8'h21, "R8 xon2 resumes");
    send(8'h11, "R8 xon1 written in mode01");
    send(8'h13, "R8 xoff1 written in mode01");

    // equal resume/stop characters
    xon2_chr = 8'h23;
    send(8'h23, "R11 equal chars act as stop");
    fc_mode = 2'b10;
    xon1_chr = 8'h13;
    send(8'h13, "R11 equal chars pair1");
    fc_mode = 2'b00;
    spec_en = 1'b1;
    send(8'h23, "R4 special in mode00 written");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule